// File: doc/BRIEF.md
# Pixel Cell with Three-Event Hit Storage

This block is the digital part of one pixel in a hit-detecting sensor matrix. A binary discriminator output (active low) is captured into one of three hit memories, each opened by its own active-low strobe window. The memories can therefore hold up to three separate events. A separate active-low memory select chooses which memory is shown to the column priority encoder. When the encoder has read that memory, it clears it by pulsing its clear line; the clear acts on the falling edge of that pulse.

Two configuration bits, pulse-enable and mask, are written through a row/column addressed bus. A test pulse can either force a hit into the strobed memories (digital mode) or drive an output that requests analog charge injection (analog mode). The mask gates only the hit output; the stored hits are kept. The model is synchronous to `clk`, and the global reset clears the memories asynchronously.

The encoder-clear edge detector is a two-state machine. In `CLR_IDLE` the clear input was last sampled low. `CLR_IDLE -> CLR_ARMED` is taken when it is sampled high, and `CLR_ARMED` holds while it stays high. `CLR_ARMED -> CLR_IDLE` is taken when it is sampled low. On that transition the clear strobe fires for the selected memory in the same clock edge.

Top module: `pix_cell`

## Requirements
- R1: While `prst_n` is 0, all three hit memories are cleared at once without waiting for a clock edge, so `state_out` is 0 for every memory select.
- R2: At a rising `clk` edge, memory i is set when `strobe_n[i]` is 0 and `disc_n` is 0. A memory whose strobe is 1 keeps its value, and nothing is set while `disc_n` is 1.
- R3: `memsel_n` is active low with bit i selecting memory i. If several bits are 0, the lowest index wins. If none is 0, `state_out` is 0. `state_out` follows `memsel_n` combinationally.
- R4: At the first clock edge where `enc_clr` is sampled 0 after having been sampled 1, only the selected memory is cleared. A held high or held low level clears nothing.
- R5: If a set (R2 or R8) and a clear (R4) hit the same memory at the same edge, the memory ends up cleared.
- R6: `state_out` is 1 only when the selected memory holds a hit and the mask bit is 0. Setting the mask does not erase the stored hits.
- R7: A configuration write takes place at a clock edge only when `cfg_col` and `cfg_row` are both 1. The value stored is `cfg_data`, and `cfg_reg` = 0 targets pulse-enable while `cfg_reg` = 1 targets the mask.
- R8: With pulse-enable 1, `pulse_type` 0 and `pulse` 1, each memory whose strobe is 0 is set at the edge, even with `disc_n` at 1. With pulse-enable 0, `pulse` has no effect.
- R9: `apulse_out` is 1 exactly when `pulse`, pulse-enable and `pulse_type` are all 1. It changes combinationally, and analog pulsing sets no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for memories, configuration and clear detector |
| prst_n | input | 1 | Global reset of hit memories, active low, asynchronous |
| disc_n | input | 1 | Discriminator output, active low |
| strobe_n | input | 3 | Strobe windows, one per memory, active low |
| memsel_n | input | 3 | Memory select for readout and clear, active low |
| enc_clr | input | 1 | Clear from priority encoder, acts on falling edge |
| cfg_data | input | 1 | Configuration data bit |
| cfg_col | input | 1 | Column select for configuration |
| cfg_row | input | 1 | Row select for configuration |
| cfg_reg | input | 1 | Target: 0 pulse-enable, 1 mask |
| pulse_type | input | 1 | 0 digital pulsing, 1 analog pulsing |
| pulse | input | 1 | Test pulse |
| state_out | output | 1 | Selected hit, gated by mask |
| apulse_out | output | 1 | Analog injection request |

## Verification
Memory capture, encoder clears and configuration writes take effect at the first rising edge after their inputs are applied. `state_out` then shows the result in the same cycle through combinational select and mask logic. `apulse_out`, the memory-select change and the global reset act with no clock at all. The bench changes inputs on the falling edge and samples one nanosecond after the rising edge for clocked results. For combinational results it samples one nanosecond after driving the input.

// File: rtl/pix_pkg.sv
package pix_pkg;
    localparam int PIX_NMEM = 3;

    typedef enum logic [0:0] {
        CLR_IDLE  = 1'b0,
        CLR_ARMED = 1'b1
    } clr_state_t;
endpackage

// File: rtl/pix_cfg_regs.sv
module pix_cfg_regs (
    input  logic clk,
    input  logic cfg_data,
    input  logic cfg_col,
    input  logic cfg_row,
    input  logic cfg_reg,
    output logic pulse_en,
    output logic mask_en
);
    logic wr_en;

    always_comb wr_en = cfg_col & cfg_row;

    always_ff @(posedge clk) begin
        if (wr_en && !cfg_reg) pulse_en <= cfg_data;
        if (wr_en &&  cfg_reg) mask_en  <= cfg_data;
    end
endmodule

// File: rtl/pix_clr_fsm.sv
module pix_clr_fsm
    import pix_pkg::*;
(
    input  logic clk,
    input  logic prst_n,
    input  logic enc_clr,
    output logic clr_fire,
    output logic clr_armed
);
    clr_state_t cs, ns;

    // state register
    always_ff @(posedge clk or negedge prst_n) begin
        if (!prst_n) cs <= CLR_IDLE;
        else         cs <= ns;
    end

    // next state and outputs
    always_comb begin
        ns        = cs;
        clr_fire  = 1'b0;
        clr_armed = 1'b0;
        unique case (cs)
            CLR_IDLE: begin
                if (enc_clr) ns = CLR_ARMED;
            end
            CLR_ARMED: begin
                clr_armed = 1'b1;
                if (!enc_clr) begin
                    ns       = CLR_IDLE;
                    clr_fire = 1'b1;
                end
            end
            default: ns = CLR_IDLE;
        endcase
    end
endmodule

// File: rtl/pix_hit_mem.sv
module pix_hit_mem #(
    parameter int NMEM = 3
) (
    input  logic            clk,
    input  logic            prst_n,
    input  logic [NMEM-1:0] set_vec,
    input  logic [NMEM-1:0] clr_vec,
    output logic [NMEM-1:0] mem_q
);
    for (genvar i = 0; i < NMEM; i++) begin : g_bit
        always_ff @(posedge clk or negedge prst_n) begin
            if (!prst_n)         mem_q[i] <= 1'b0;
            else if (clr_vec[i]) mem_q[i] <= 1'b0;
            else if (set_vec[i]) mem_q[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/pix_cell.sv
module pix_cell
    import pix_pkg::*;
#(
    parameter int NMEM = PIX_NMEM
) (
    input  logic            clk,
    input  logic            prst_n,
    input  logic            disc_n,
    input  logic [NMEM-1:0] strobe_n,
    input  logic [NMEM-1:0] memsel_n,
    input  logic            enc_clr,
    input  logic            cfg_data,
    input  logic            cfg_col,
    input  logic            cfg_row,
    input  logic            cfg_reg,
    input  logic            pulse_type,
    input  logic            pulse,
    output logic            state_out,
    output logic            apulse_out
);
    logic            pulse_en, mask_en;
    logic            clr_fire, clr_armed;
    logic            dpulse;
    logic [NMEM-1:0] sel_oh, set_vec, clr_vec, mem_q;

    pix_cfg_regs u_cfg (
        .clk      (clk),
        .cfg_data (cfg_data),
        .cfg_col  (cfg_col),
        .cfg_row  (cfg_row),
        .cfg_reg  (cfg_reg),
        .pulse_en (pulse_en),
        .mask_en  (mask_en)
    );

    pix_clr_fsm u_clr (
        .clk       (clk),
        .prst_n    (prst_n),
        .enc_clr   (enc_clr),
        .clr_fire  (clr_fire),
        .clr_armed (clr_armed)
    );

    // lowest active select wins
    always_comb begin
        sel_oh = '0;
        for (int i = NMEM - 1; i >= 0; i--) begin
            if (!memsel_n[i]) sel_oh = NMEM'(1) << i;
        end
    end

    always_comb begin
        dpulse     = pulse & pulse_en & ~pulse_type;
        apulse_out = pulse & pulse_en & pulse_type;
        set_vec    = ~strobe_n & {NMEM{~disc_n | dpulse}};
        clr_vec    = sel_oh & {NMEM{clr_fire}};
        state_out  = (|(mem_q & sel_oh)) & ~mask_en;
    end

    pix_hit_mem #(.NMEM(NMEM)) u_mem (
        .clk     (clk),
        .prst_n  (prst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .mem_q   (mem_q)
    );
endmodule

// File: rtl/pix_cell_chk.sv
module pix_cell_chk #(
    parameter int NMEM = 3
) (
    input logic            clk,
    input logic            prst_n,
    input logic            disc_n,
    input logic [NMEM-1:0] strobe_n,
    input logic [NMEM-1:0] memsel_n,
    input logic            enc_clr,
    input logic            cfg_data,
    input logic            cfg_col,
    input logic            cfg_row,
    input logic            cfg_reg,
    input logic            pulse_type,
    input logic            pulse,
    input logic            state_out,
    input logic            apulse_out,
    input logic [NMEM-1:0] mem_q,
    input logic            clr_armed
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !prst_n |-> (mem_q == '0) && !state_out);

    // R2
    capture_bit0_chk: assert property (@(posedge clk) disable iff (!prst_n)
        (!strobe_n[0] && !disc_n && enc_clr) |=> mem_q[0]);

    // R4
    clear_selected_chk: assert property (@(posedge clk) disable iff (!prst_n)
        (clr_armed && !enc_clr && memsel_n[0] == 1'b0) |=> !mem_q[0]);

    // R4
    clear_spares_other_chk: assert property (@(posedge clk) disable iff (!prst_n)
        (clr_armed && !enc_clr && memsel_n[0] == 1'b0 && strobe_n[1]) |=> $stable(mem_q[1]));

    // R6
    mask_write_chk: assert property (@(posedge clk) disable iff (!prst_n)
        (cfg_col && cfg_row && cfg_reg && cfg_data) |=> !state_out);

    // R9
    apulse_digital_chk: assert property (@(posedge clk) disable iff (!prst_n)
        (!pulse_type || !pulse) |-> !apulse_out);

    // R3
    no_select_chk: assert property (@(posedge clk) disable iff (!prst_n)
        (&memsel_n) |-> !state_out);
endmodule

bind pix_cell pix_cell_chk #(.NMEM(NMEM)) u_chk (
    .clk        (clk),
    .prst_n     (prst_n),
    .disc_n     (disc_n),
    .strobe_n   (strobe_n),
    .memsel_n   (memsel_n),
    .enc_clr    (enc_clr),
    .cfg_data   (cfg_data),
    .cfg_col    (cfg_col),
    .cfg_row    (cfg_row),
    .cfg_reg    (cfg_reg),
    .pulse_type (pulse_type),
    .pulse      (pulse),
    .state_out  (state_out),
    .apulse_out (apulse_out),
    .mem_q      (mem_q),
    .clr_armed  (clr_armed)
);

// File: tb/tb_pix_cell.sv
module tb_pix_cell;
    logic       clk = 1'b0;
    logic       prst_n = 1'b0;
    logic       disc_n = 1'b1;
    logic [2:0] strobe_n = 3'b111;
    logic [2:0] memsel_n = 3'b111;
    logic       enc_clr = 1'b0;
    logic       cfg_data = 1'b0, cfg_col = 1'b0, cfg_row = 1'b0, cfg_reg = 1'b0;
    logic       pulse_type = 1'b0, pulse = 1'b0;
    logic       state_out, apulse_out;
    int         n_checks = 0, n_fail = 0;

    always #5 clk = ~clk;

    pix_cell dut (
        .clk(clk), .prst_n(prst_n), .disc_n(disc_n), .strobe_n(strobe_n),
        .memsel_n(memsel_n), .enc_clr(enc_clr), .cfg_data(cfg_data),
        .cfg_col(cfg_col), .cfg_row(cfg_row), .cfg_reg(cfg_reg),
        .pulse_type(pulse_type), .pulse(pulse),
        .state_out(state_out), .apulse_out(apulse_out)
    );

    // {strobe_n, disc_n, enc_clr, memsel_n, expected state_out}
    localparam logic [8:0] VEC [15] = '{
        {3'b111, 1'b0, 1'b0, 3'b110, 1'b0},  // R2 no strobe
        {3'b110, 1'b1, 1'b0, 3'b110, 1'b0},  // R2 disc idle
        {3'b110, 1'b0, 1'b0, 3'b110, 1'b1},  // R2 capture bit0
        {3'b101, 1'b0, 1'b0, 3'b101, 1'b1},  // R2 capture bit1
        {3'b111, 1'b1, 1'b0, 3'b011, 1'b0},  // R3 bit2 empty
        {3'b111, 1'b1, 1'b0, 3'b010, 1'b1},  // R3 lowest wins
        {3'b111, 1'b1, 1'b0, 3'b111, 1'b0},  // R3 none selected
        {3'b111, 1'b1, 1'b1, 3'b101, 1'b1},  // R4 clear high
        {3'b111, 1'b1, 1'b1, 3'b101, 1'b1},  // R4 held high
        {3'b111, 1'b1, 1'b0, 3'b101, 1'b0},  // R4 falling edge clears bit1
        {3'b111, 1'b1, 1'b0, 3'b110, 1'b1},  // R4 bit0 kept
        {3'b111, 1'b1, 1'b0, 3'b110, 1'b1},  // R4 held low
        {3'b011, 1'b0, 1'b1, 3'b011, 1'b1},  // R2 capture bit2
        {3'b011, 1'b0, 1'b0, 3'b011, 1'b0},  // R5 clear beats set
        {3'b111, 1'b1, 1'b0, 3'b110, 1'b1}   // R5 bit0 untouched
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic col, input logic row, input logic rsel, input logic d);
        @(negedge clk);
        cfg_col = col; cfg_row = row; cfg_reg = rsel; cfg_data = d;
        tick();
        @(negedge clk);
        cfg_col = 1'b0; cfg_row = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        cfg_write(1, 1, 0, 0);
        cfg_write(1, 1, 1, 0);
        for (int s = 0; s < 3; s++) begin
            memsel_n = ~(3'b001 << s);
            #1 check("R1 reset state", state_out, 1'b0);
        end
        @(negedge clk);
        prst_n = 1'b1;

        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            {strobe_n, disc_n, enc_clr, memsel_n} = VEC[i][8:1];
            tick();
            check($sformatf("vector %0d", i), state_out, VEC[i][0]);
        end
        @(negedge clk);
        strobe_n = 3'b111; disc_n = 1'b1; enc_clr = 1'b0; memsel_n = 3'b110;

        // R6 mask hides, then unmask reveals retained hit
        cfg_write(1, 1, 1, 1);
        check("R6 masked", state_out, 1'b0);
        cfg_write(1, 1, 1, 0);
        check("R6 unmasked hit kept", state_out, 1'b1);

        // R7 write needs both selects
        cfg_write(1, 0, 1, 1);
        check("R7 column only", state_out, 1'b1);
        cfg_write(0, 1, 1, 1);
        check("R7 row only", state_out, 1'b1);

        // R8 digital pulse with pulse-enable off
        @(negedge clk);
        memsel_n = 3'b101; strobe_n = 3'b101; pulse_type = 1'b0; pulse = 1'b1;
        tick();
        check("R8 pulse disabled", state_out, 1'b0);
        @(negedge clk);
        strobe_n = 3'b111; pulse = 1'b0;
        cfg_write(1, 1, 0, 1);
        @(negedge clk);
        strobe_n = 3'b101; pulse = 1'b1;
        #1 check("R9 digital no apulse", apulse_out, 1'b0);
        tick();
        check("R8 digital pulse sets bit1", state_out, 1'b1);

        // R9 analog pulse
        @(negedge clk);
        strobe_n = 3'b011; memsel_n = 3'b011; pulse_type = 1'b1;
        #1 check("R9 apulse high", apulse_out, 1'b1);
        tick();
        check("R9 analog sets nothing", state_out, 1'b0);
        @(negedge clk);
        pulse = 1'b0;
        #1 check("R9 apulse low", apulse_out, 1'b0);
        strobe_n = 3'b111;

        // R1 asynchronous global reset
        #2 prst_n = 1'b0;
        for (int s = 0; s < 3; s++) begin
            memsel_n = ~(3'b001 << s);
            #1 check("R1 async clear", state_out, 1'b0);
        end
        @(negedge clk);
        prst_n = 1'b1;
        memsel_n = 3'b110;
        tick();
        check("R1 stays clear", state_out, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule